// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder

This block turns one 16-bit instruction word into the full set of control signals for a single-cycle processor. It has no state. Each output is a fixed function of fixed bit positions in the instruction, so no lookup table is needed.

The instruction has four fields. The opcode sits in bits 15:9. The destination register field is bits 8:6, source A is bits 5:3, and source B is bits 2:0.

From these fields the block drives the following outputs:

- three register-file addresses;
- a 4-bit ALU function code;
- the operand-B and write-back mux selects;
- the register and memory write enables;
- the program-counter load, jump and branch-condition selects;
- a zero-filled constant;
- a sign-extended branch offset.

The register file, ALU, memories and PC register are outside this block. They consume these outputs in the same cycle.

Top module: `scdec_top`

## Requirements
- R1: `dst_sel`, `srca_sel` and `srcb_sel` equal instruction bits 8:6, 5:3 and 2:0 respectively.
- R2: `alu_func` equals instruction bits 12:9, the low four bits of the opcode. This holds for every opcode, including those whose top three bits are 000 (ALU and shift operations).
- R3: `imm_zf` is instruction bits 2:0 placed in its low three bits, with all upper bits zero.
- R4: `br_off` is the 6-bit value {bits 8:6, bits 2:0}, sign-extended to 16 bits. Bit 8 is the sign.
- R5: `bsrc_imm` (1 selects the constant as operand B) equals bit 15.
- R6: `wb_mem` (1 selects memory data for register write-back) equals bit 13.
- R7: `reg_we` is the inverse of bit 14.
- R8: `mem_we` is 1 only when bit 14 is 1 and bit 15 is 0.
- R9: `pc_load` is 1 only when bits 15 and 14 are both 1.
- R10: `pc_jump` (1 selects an unconditional jump, 0 a conditional branch) equals bit 13.
- R11: `br_neg` (1 tests the negative flag, 0 tests the zero flag) equals bit 9, the last opcode bit.
- R12: Outputs depend only on the present instruction. The same word gives the same outputs whatever words came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word |
| dst_sel | output | 3 | Destination register address |
| srca_sel | output | 3 | Source A register address |
| srcb_sel | output | 3 | Source B register address |
| alu_func | output | 4 | ALU function code |
| bsrc_imm | output | 1 | Operand B mux select (1 = constant) |
| wb_mem | output | 1 | Write-back mux select (1 = memory) |
| reg_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Data memory write enable |
| pc_load | output | 1 | PC takes a non-sequential value |
| pc_jump | output | 1 | 1 = unconditional jump, 0 = conditional branch |
| br_neg | output | 1 | Branch condition select (1 = negative, 0 = zero) |
| imm_zf | output | 16 | Zero-filled constant |
| br_off | output | 16 | Sign-extended branch offset |

## Verification
The table covers opcode classes that set different combinations of the top three opcode bits: ALU, load, store, immediate, conditional branch, jump, and all ones. Each of these classes produces a distinct control-flag pattern, so a swapped or inverted flag shows up as a mismatch.

All table entries share fixed, non-symmetric register fields. This separates the three address outputs from one another and tells an offset built from the wrong fields from the correct one.

Directed words exercise the offset at its most positive and most negative values. They also give each address field a distinct nonzero value, and they repeat a word after a very different one to confirm that no state is kept.

// File: rtl/scdec_pkg.sv
package scdec_pkg;

   typedef struct packed {
      logic bsrc_imm;
      logic wb_mem;
      logic reg_we;
      logic mem_we;
      logic pc_load;
      logic pc_jump;
      logic br_neg;
   } scdec_ctrl_t;

   localparam int unsigned CLASS_BITS = 3;

endpackage

// File: rtl/scdec_fields.sv
module scdec_fields #(
   parameter int unsigned INSTR_W = 16,
   parameter int unsigned OPC_W   = 7,
   parameter int unsigned REG_AW  = 3
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [OPC_W-1:0]   opcode,
   output logic [REG_AW-1:0]  dst,
   output logic [REG_AW-1:0]  srca,
   output logic [REG_AW-1:0]  srcb
);
   localparam int unsigned SB_LO  = 0;
   localparam int unsigned SA_LO  = SB_LO + REG_AW;
   localparam int unsigned DR_LO  = SA_LO + REG_AW;
   localparam int unsigned OPC_LO = DR_LO + REG_AW;

   always_comb begin
      opcode = instr[OPC_LO +: OPC_W];
      dst    = instr[DR_LO  +: REG_AW];
      srca   = instr[SA_LO  +: REG_AW];
      srcb   = instr[SB_LO  +: REG_AW];
   end
endmodule

// File: rtl/scdec_ctrl.sv
module scdec_ctrl
   import scdec_pkg::*;
#(
   parameter int unsigned OPC_W = 7,
   parameter int unsigned FS_W  = 4
) (
   input  logic [OPC_W-1:0] opcode,
   output scdec_ctrl_t      ctrl,
   output logic [FS_W-1:0]  alu_func
);
   localparam int unsigned TOP = OPC_W - 1;

   logic c2, c1, c0;

   always_comb begin
      c2 = opcode[TOP];
      c1 = opcode[TOP-1];
      c0 = opcode[TOP-2];
      ctrl.bsrc_imm = c2;
      ctrl.wb_mem   = c0;
      ctrl.reg_we   = ~c1;
      ctrl.mem_we   = c1 & ~c2;
      ctrl.pc_load  = c1 & c2;
      ctrl.pc_jump  = c0;
      ctrl.br_neg   = opcode[0];
      alu_func      = opcode[FS_W-1:0];
   end
endmodule

// File: rtl/scdec_ext.sv
module scdec_ext #(
   parameter int unsigned REG_AW = 3,
   parameter int unsigned DATA_W = 16
) (
   input  logic [REG_AW-1:0] dst,
   input  logic [REG_AW-1:0] srcb,
   output logic [DATA_W-1:0] imm,
   output logic [DATA_W-1:0] off
);
   localparam int unsigned OFF_W = 2 * REG_AW;

   logic [OFF_W-1:0] raw_off;
   assign raw_off = {dst, srcb};

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i < REG_AW) begin : g_imm_lo
         assign imm[i] = srcb[i];
      end else begin : g_imm_hi
         assign imm[i] = 1'b0;
      end
      if (i < OFF_W) begin : g_off_lo
         assign off[i] = raw_off[i];
      end else begin : g_off_hi
         assign off[i] = raw_off[OFF_W-1];
      end
   end
endmodule

// File: rtl/scdec_top.sv
module scdec_top
   import scdec_pkg::*;
#(
   parameter int unsigned INSTR_W = 16,
   parameter int unsigned OPC_W   = 7,
   parameter int unsigned REG_AW  = 3,
   parameter int unsigned FS_W    = 4,
   parameter int unsigned DATA_W  = 16
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [REG_AW-1:0]  dst_sel,
   output logic [REG_AW-1:0]  srca_sel,
   output logic [REG_AW-1:0]  srcb_sel,
   output logic [FS_W-1:0]    alu_func,
   output logic               bsrc_imm,
   output logic               wb_mem,
   output logic               reg_we,
   output logic               mem_we,
   output logic               pc_load,
   output logic               pc_jump,
   output logic               br_neg,
   output logic [DATA_W-1:0]  imm_zf,
   output logic [DATA_W-1:0]  br_off
);
   if (OPC_W + 3 * REG_AW != INSTR_W) begin : g_chk_layout
      $error("scdec_top: opcode and register fields must fill the instruction");
   end
   if (FS_W + CLASS_BITS > OPC_W) begin : g_chk_fs
      $error("scdec_top: function code overlaps the class bits");
   end
   if (DATA_W < 2 * REG_AW) begin : g_chk_data
      $error("scdec_top: data width too small for the branch offset");
   end

   logic [OPC_W-1:0] opcode;
   scdec_ctrl_t      ctrl;

   scdec_fields #(.INSTR_W(INSTR_W), .OPC_W(OPC_W), .REG_AW(REG_AW)) u_fields (
      .instr (instr),
      .opcode(opcode),
      .dst   (dst_sel),
      .srca  (srca_sel),
      .srcb  (srcb_sel)
   );

   scdec_ctrl #(.OPC_W(OPC_W), .FS_W(FS_W)) u_ctrl (
      .opcode  (opcode),
      .ctrl    (ctrl),
      .alu_func(alu_func)
   );

   scdec_ext #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_ext (
      .dst (dst_sel),
      .srcb(srcb_sel),
      .imm (imm_zf),
      .off (br_off)
   );

   always_comb begin
      bsrc_imm = ctrl.bsrc_imm;
      wb_mem   = ctrl.wb_mem;
      reg_we   = ctrl.reg_we;
      mem_we   = ctrl.mem_we;
      pc_load  = ctrl.pc_load;
      pc_jump  = ctrl.pc_jump;
      br_neg   = ctrl.br_neg;
   end
endmodule

// File: rtl/scdec_checker.sv
module scdec_checker (
   input logic [15:0] instr,
   input logic [2:0]  dst_sel,
   input logic [2:0]  srca_sel,
   input logic [2:0]  srcb_sel,
   input logic [3:0]  alu_func,
   input logic        bsrc_imm,
   input logic        wb_mem,
   input logic        reg_we,
   input logic        mem_we,
   input logic        pc_load,
   input logic        pc_jump,
   input logic        br_neg,
   input logic [15:0] imm_zf,
   input logic [15:0] br_off
);
   always_comb begin
      assert_fields_R1: assert ({dst_sel, srca_sel, srcb_sel} == instr[8:0]);
      assert_func_R2:   assert (alu_func == instr[12:9]);
      assert_imm_R3:    assert (imm_zf[15:3] == 13'd0 && imm_zf[2:0] == instr[2:0]);
      assert_off_R4:    assert (br_off[5:0] == {instr[8:6], instr[2:0]}
                                && (br_off[15:6] == {10{instr[8]}}));
      assert_store_R8:  assert (!(mem_we && (reg_we || pc_load)));
      assert_pc_R9:     assert (!pc_load || (bsrc_imm && !reg_we));
   end
endmodule

bind scdec_top scdec_checker u_chk (.*);

// File: tb/sim_scdec_top.sv
`timescale 1ns/1ps
module sim_scdec_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [15:0] instr;
   logic [2:0]  dst_sel, srca_sel, srcb_sel;
   logic [3:0]  alu_func;
   logic        bsrc_imm, wb_mem, reg_we, mem_we, pc_load, pc_jump, br_neg;
   logic [15:0] imm_zf, br_off;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   scdec_top u0 (.*);

   // vector: instr, flags {bsrc_imm,wb_mem,reg_we,mem_we,pc_load,pc_jump,br_neg}, func
   localparam int NV = 10;
   localparam logic [26:0] VEC [NV] = '{
      {16'h055E, 7'b0010000, 4'h2},   // ALU op
      {16'h0B5E, 7'b0010001, 4'h5},   // ALU op, odd code
      {16'h215E, 7'b0110010, 4'h0},   // load
      {16'h415E, 7'b0001000, 4'h0},   // store
      {16'h995E, 7'b1010000, 4'hC},   // load immediate
      {16'h855E, 7'b1010000, 4'h2},   // add immediate
      {16'hC15E, 7'b1000100, 4'h0},   // branch on zero
      {16'hC35E, 7'b1000101, 4'h1},   // branch on negative
      {16'hE15E, 7'b1100110, 4'h0},   // jump
      {16'h1F5E, 7'b0010001, 4'hF}    // ALU op, all function bits
   };

   function automatic logic [6:0] flags();
      return {bsrc_imm, wb_mem, reg_we, mem_we, pc_load, pc_jump, br_neg};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h (instr=%h)", req, act, exp, instr);
      end
   endtask

   task automatic apply(input logic [15:0] w);
      @(negedge clk);
      instr = w;
      #2;
   endtask

   task automatic check_fields(input logic [2:0] d, input logic [2:0] a, input logic [2:0] b,
                               input logic [15:0] imm, input logic [15:0] off);
      check("R1 dst", 32'(dst_sel), 32'(d));
      check("R1 srca", 32'(srca_sel), 32'(a));
      check("R1 srcb", 32'(srcb_sel), 32'(b));
      check("R3 imm", 32'(imm_zf), 32'(imm));
      check("R4 off", 32'(br_off), 32'(off));
   endtask

   initial begin
      #100000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      instr = 16'h0000;
      repeat (3) @(posedge clk);
      #2;
      // reset-time state with a zero word: R7 write enable on, everything else zero
      check("R7 reset flags", 32'(flags()), 32'(7'b0010000));
      check("R2 reset func", 32'(alu_func), 32'h0);
      check_fields(3'd0, 3'd0, 3'd0, 16'h0000, 16'h0000);
      rst_n = 1'b1;

      // R5 R6 R7 R8 R9 R10 R11 R2 over the opcode classes
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][26:11]);
         check("R5-flags(R6 R7 R8 R9 R10 R11)", 32'(flags()), 32'(VEC[i][10:4]));
         check("R2 func", 32'(alu_func), 32'(VEC[i][3:0]));
         check_fields(3'd5, 3'd3, 3'd6, 16'h0006, 16'hFFEE);
      end

      // R4 largest positive offset
      apply(16'h00C7);
      check_fields(3'd3, 3'd0, 3'd7, 16'h0007, 16'h001F);
      // R4 most negative offset
      apply(16'h0100);
      check_fields(3'd4, 3'd0, 3'd0, 16'h0000, 16'hFFE0);
      // R1 source A alone
      apply(16'h0038);
      check_fields(3'd0, 3'd7, 3'd0, 16'h0000, 16'h0000);
      // all ones: R9 load with jump, R11 negative select
      apply(16'hFFFF);
      check("R9 all-ones flags", 32'(flags()), 32'(7'b1100111));
      check("R2 all-ones func", 32'(alu_func), 32'hF);
      check_fields(3'd7, 3'd7, 3'd7, 16'h0007, 16'hFFFF);
      // R12 repeat the first vector after all ones
      apply(VEC[0][26:11]);
      check("R12 no history flags", 32'(flags()), 32'(VEC[0][10:4]));
      check("R12 no history func", 32'(alu_func), 32'(VEC[0][3:0]));

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule